// File: doc/BRIEF.md
# Single-Slot Command Issue Sequencer

This block is a small controller that runs one already-prepared command on a storage host port, always through command slot 0. It owns a register master port with one-cycle read latency. Through that port it performs the whole issue handshake: it zeroes the transfer-count word of the command header and waits until the device reports idle. It then turns on command processing and issues slot 0. It polls for a port interrupt, acknowledges it and judges the outcome from the frame-received status bits. Last, it acknowledges the global interrupt and turns command processing off again, but only once the slot has retired.

Software or a higher-level engine pulses `go` once the command header and table are in memory. `busy` stays high for the whole sequence. A one-cycle `done` pulse marks the end. `error` then holds the outcome until the next command starts. If no interrupt arrives within a set number of polls, the block gives up and reports an error.

All register offsets are parameters. The bit positions listed in the requirements are fixed, because the port hardware decodes them.

Top module: `cmd_slot_seq`

## Requirements
- R1: After reset, `busy`, `done`, `error`, `reg_rd` and `reg_wr` are all low.
- R2: A `go` pulse while idle raises `busy` in the next cycle. In that same cycle the block writes 0 to the transfer-count address `A_XFER`.
- R3: The block reads `A_TASK` again and again until bit 7 (busy) and bit 3 (data request) are both clear. It then reads `A_CTL` and writes that value back with bit 0 (start) set.
- R4: In the cycle right after the start write, the block writes the value 1 to `A_ISSUE` (slot 0 issued).
- R5: The block then reads `A_PIS` until the value is non-zero. It writes exactly that value back to `A_PIS`.
- R6: If bit 6 (connect change) of that status is set, the block does two things before the write-back: it reads `A_SERR`, then writes it back with bits 16 and 26 cleared.
- R7: `error` is set when none of status bits 0, 1 and 2 is set. It is clear when at least one of them is set.
- R8: After the port acknowledge, the block reads `A_GIS` and writes the same value back.
- R9: The block reads `A_CTL` and then `A_ISSUE`. It writes `A_CTL` with bit 0 cleared only if the control value has bit 0 set and the issue value has bit 0 clear. Otherwise it makes no write.
- R10: After `POLL_LIMIT` zero reads of `A_PIS` in a row, the block ends with `error` set and makes no further register access.
- R11: The end of a sequence is a single-cycle `done` pulse. `busy` is low in the cycle after it. `error` keeps its value until the next accepted `go`.
- R12: A `go` pulse while `busy` is high has no effect on the access sequence.
- R13: `reg_rd` and `reg_wr` are never high together. Read data is taken in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start pulse |
| reg_rdata | input | DW | Read data, valid one cycle after `reg_rd` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Outcome of the last command (1 = failed or timed out) |
| reg_rd | output | 1 | Register read strobe |
| reg_wr | output | 1 | Register write strobe |
| reg_addr | output | AW | Register address |
| reg_wdata | output | DW | Register write data |

## Verification
The hardest conditions to reach are those that depend on the device's reply timing. These are: several busy task-file reads before start, the exact poll at which the interrupt arrives relative to `POLL_LIMIT`, and the slot still showing as issued when the stop check runs. The bench holds a scripted port model whose replies to each register are preloaded per case. This lets it place busy bits, delayed interrupts, the connect-change bit and a still-set issue bit in any mix. It includes the last poll before timeout and the first one past it. Every register access is then compared against an expected access list built from the requirements.

// File: rtl/cmd_slot_seq.sv
module cmd_slot_seq #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int POLL_LIMIT = 100000,
  parameter logic [AW-1:0] A_CTL   = 8'h00,
  parameter logic [AW-1:0] A_ISSUE = 8'h04,
  parameter logic [AW-1:0] A_TASK  = 8'h08,
  parameter logic [AW-1:0] A_PIS   = 8'h0C,
  parameter logic [AW-1:0] A_SERR  = 8'h10,
  parameter logic [AW-1:0] A_GIS   = 8'h14,
  parameter logic [AW-1:0] A_XFER  = 8'h18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [DW-1:0] reg_rdata,
  output logic          busy,
  output logic          done,
  output logic          error,
  output logic          reg_rd,
  output logic          reg_wr,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata
);
  localparam int PW = $clog2(POLL_LIMIT + 1);
  localparam logic [DW-1:0] ONE = DW'(1);
  localparam logic [DW-1:0] SERR_MASK = (ONE << 16) | (ONE << 26);

  typedef enum logic [4:0] {
    S_IDLE, S_CLR, S_TF_RD, S_TF_CHK, S_CTL_RD, S_CTL_CAP, S_START, S_ISSUE,
    S_IS_RD, S_IS_CHK, S_SERR_RD, S_SERR_CAP, S_SERR_WR, S_IS_ACK,
    S_GIS_RD, S_GIS_CAP, S_GIS_ACK, S_STP_CTL_RD, S_STP_CTL_CAP,
    S_STP_CI_RD, S_STP_CI_CHK, S_STP_WR, S_DONE
  } state_t;

  state_t        state;
  logic [DW-1:0] hold_q;
  logic [DW-1:0] sts_q;
  logic [PW-1:0] poll_q;
  logic          err_q;

  assign busy  = (state != S_IDLE);
  assign done  = (state == S_DONE);
  assign error = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      hold_q <= '0;
      sts_q  <= '0;
      poll_q <= '0;
      err_q  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (go) begin
          state <= S_CLR;
          err_q <= 1'b0;
        end
        S_CLR:     state <= S_TF_RD;
        S_TF_RD:   state <= S_TF_CHK;
        S_TF_CHK:  state <= (reg_rdata[7] | reg_rdata[3]) ? S_TF_RD : S_CTL_RD;
        S_CTL_RD:  state <= S_CTL_CAP;
        S_CTL_CAP: begin
          hold_q <= reg_rdata;
          state  <= S_START;
        end
        S_START:   state <= S_ISSUE;
        S_ISSUE: begin
          poll_q <= '0;
          state  <= S_IS_RD;
        end
        S_IS_RD:   state <= S_IS_CHK;
        S_IS_CHK: begin
          if (reg_rdata == '0) begin
            if (poll_q == PW'(POLL_LIMIT - 1)) begin
              err_q <= 1'b1;
              state <= S_DONE;
            end else begin
              poll_q <= poll_q + 1'b1;
              state  <= S_IS_RD;
            end
          end else begin
            sts_q <= reg_rdata;
            err_q <= ~|reg_rdata[2:0];
            state <= reg_rdata[6] ? S_SERR_RD : S_IS_ACK;
          end
        end
        S_SERR_RD:  state <= S_SERR_CAP;
        S_SERR_CAP: begin
          hold_q <= reg_rdata;
          state  <= S_SERR_WR;
        end
        S_SERR_WR:  state <= S_IS_ACK;
        S_IS_ACK:   state <= S_GIS_RD;
        S_GIS_RD:   state <= S_GIS_CAP;
        S_GIS_CAP: begin
          hold_q <= reg_rdata;
          state  <= S_GIS_ACK;
        end
        S_GIS_ACK:     state <= S_STP_CTL_RD;
        S_STP_CTL_RD:  state <= S_STP_CTL_CAP;
        S_STP_CTL_CAP: begin
          hold_q <= reg_rdata;
          state  <= S_STP_CI_RD;
        end
        S_STP_CI_RD:  state <= S_STP_CI_CHK;
        S_STP_CI_CHK: state <= (hold_q[0] && !reg_rdata[0]) ? S_STP_WR : S_DONE;
        S_STP_WR:     state <= S_DONE;
        S_DONE:       state <= S_IDLE;
        default:      state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    reg_rd    = 1'b0;
    reg_wr    = 1'b0;
    reg_addr  = '0;
    reg_wdata = '0;
    case (state)
      S_CLR:        begin reg_wr = 1'b1; reg_addr = A_XFER; end
      S_TF_RD:      begin reg_rd = 1'b1; reg_addr = A_TASK; end
      S_CTL_RD:     begin reg_rd = 1'b1; reg_addr = A_CTL; end
      S_START:      begin reg_wr = 1'b1; reg_addr = A_CTL;   reg_wdata = hold_q | ONE; end
      S_ISSUE:      begin reg_wr = 1'b1; reg_addr = A_ISSUE; reg_wdata = ONE; end
      S_IS_RD:      begin reg_rd = 1'b1; reg_addr = A_PIS; end
      S_SERR_RD:    begin reg_rd = 1'b1; reg_addr = A_SERR; end
      S_SERR_WR:    begin reg_wr = 1'b1; reg_addr = A_SERR;  reg_wdata = hold_q & ~SERR_MASK; end
      S_IS_ACK:     begin reg_wr = 1'b1; reg_addr = A_PIS;   reg_wdata = sts_q; end
      S_GIS_RD:     begin reg_rd = 1'b1; reg_addr = A_GIS; end
      S_GIS_ACK:    begin reg_wr = 1'b1; reg_addr = A_GIS;   reg_wdata = hold_q; end
      S_STP_CTL_RD: begin reg_rd = 1'b1; reg_addr = A_CTL; end
      S_STP_CI_RD:  begin reg_rd = 1'b1; reg_addr = A_ISSUE; end
      S_STP_WR:     begin reg_wr = 1'b1; reg_addr = A_CTL;   reg_wdata = hold_q & ~ONE; end
      default: ;
    endcase
  end
endmodule

// File: rtl/cmd_slot_seq_chk.sv
module cmd_slot_seq_chk #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter logic [AW-1:0] A_CTL   = 8'h00,
  parameter logic [AW-1:0] A_ISSUE = 8'h04,
  parameter logic [AW-1:0] A_TASK  = 8'h08,
  parameter logic [AW-1:0] A_PIS   = 8'h0C
) (
  input logic          clk,
  input logic          rst_n,
  input logic          go,
  input logic          busy,
  input logic          done,
  input logic          reg_rd,
  input logic          reg_wr,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic [DW-1:0] reg_rdata
);
  logic          rd_d;
  logic [AW-1:0] rd_addr_d;
  logic [DW-1:0] tf_last, is_last, ci_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_d      <= 1'b0;
      rd_addr_d <= '0;
      tf_last   <= '1;
      is_last   <= '0;
      ci_last   <= '1;
    end else begin
      rd_d      <= reg_rd;
      rd_addr_d <= reg_addr;
      if (rd_d && rd_addr_d == A_TASK) tf_last <= reg_rdata;
      if (rd_d && rd_addr_d == A_PIS && reg_rdata != '0) is_last <= reg_rdata;
      if (rd_d && rd_addr_d == A_ISSUE) ci_last <= reg_rdata;
    end
  end

  // R13
  rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd && reg_wr));

  // R3
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_CTL && reg_wdata[0]) |-> (!tf_last[7] && !tf_last[3]));

  // R4
  issue_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_ISSUE) |-> $past(reg_wr && reg_addr == A_CTL && reg_wdata[0]));

  // R5
  status_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_PIS) |-> (reg_wdata == is_last && is_last != '0));

  // R9
  stop_retired_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_CTL && !reg_wdata[0]) |-> !ci_last[0]);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R12
  go_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && go) |=> busy);
endmodule

bind cmd_slot_seq cmd_slot_seq_chk #(
  .AW(AW), .DW(DW), .A_CTL(A_CTL), .A_ISSUE(A_ISSUE), .A_TASK(A_TASK), .A_PIS(A_PIS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .done(done),
  .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
);

// File: tb/tb_cmd_slot_seq.sv
`timescale 1ns/1ps
module tb_cmd_slot_seq;
  localparam int POLL = 6;
  localparam logic [7:0] A_CTL = 8'h00, A_ISSUE = 8'h04, A_TASK = 8'h08, A_PIS = 8'h0C,
                         A_SERR = 8'h10, A_GIS = 8'h14, A_XFER = 8'h18;

  logic clk = 1'b0, rst_n = 1'b0, go = 1'b0;
  logic [31:0] reg_rdata = 32'h0;
  logic busy, done, error, reg_rd, reg_wr;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;

  int vectors = 0, miscompares = 0, cyc = 0;

  cmd_slot_seq #(.AW(8), .DW(32), .POLL_LIMIT(POLL),
    .A_CTL(A_CTL), .A_ISSUE(A_ISSUE), .A_TASK(A_TASK), .A_PIS(A_PIS),
    .A_SERR(A_SERR), .A_GIS(A_GIS), .A_XFER(A_XFER)) dut (
    .clk(clk), .rst_n(rst_n), .go(go), .reg_rdata(reg_rdata),
    .busy(busy), .done(done), .error(error), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata));

  always #2.5 clk = ~clk;

  // scripted port model
  logic        load = 1'b0;
  int          cfg_tf_n = 0, cfg_is_n = 0;
  logic [31:0] cfg_tf_v = 0, cfg_is_v = 0, cfg_ci = 0, cfg_ctl = 0, cfg_serr = 0, cfg_gis = 0;
  int          tf_left = 0, is_left = 0;
  logic [31:0] tf_v = 0, is_v = 0, ci_v = 0;
  logic [31:0] regs [0:7];

  always @(posedge clk) begin
    if (load) begin
      tf_left <= cfg_tf_n; tf_v <= cfg_tf_v; is_left <= cfg_is_n; is_v <= cfg_is_v; ci_v <= cfg_ci;
      regs[0] <= cfg_ctl; regs[4] <= cfg_serr; regs[5] <= cfg_gis; regs[6] <= 32'hDEAD_BEEF;
    end else begin
      if (reg_rd) begin
        if (reg_addr == A_TASK) begin
          if (tf_left > 0) begin reg_rdata <= tf_v; tf_left <= tf_left - 1; end
          else reg_rdata <= 32'h0000_0050;
        end else if (reg_addr == A_PIS) begin
          if (is_left > 0) begin reg_rdata <= 32'h0; is_left <= is_left - 1; end
          else reg_rdata <= is_v;
        end else if (reg_addr == A_ISSUE) reg_rdata <= ci_v;
        else reg_rdata <= regs[reg_addr[4:2]];
      end else reg_rdata <= 32'hA5A5_A5A5;
      if (reg_wr) regs[reg_addr[4:2]] <= reg_wdata;
    end
  end

  bit          q_wr[$];
  logic [7:0]  q_addr[$];
  logic [31:0] q_data[$];
  string       q_tag[$];

  task automatic expect_acc(bit wr, logic [7:0] a, logic [31:0] d, string tag);
    q_wr.push_back(wr); q_addr.push_back(a); q_data.push_back(d); q_tag.push_back(tag);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-clock comparison of bus activity against the expected access list
  always @(negedge clk) begin
    if (rst_n) begin
      if (reg_rd && reg_wr) chk("R13 rd and wr together", 32'd1, 32'd0);
      if (reg_rd || reg_wr) begin
        if (q_wr.size() == 0) begin
          chk("R12 unexpected access addr", {24'h0, reg_addr}, 32'hFFFF_FFFF);
        end else begin
          automatic bit          ew = q_wr.pop_front();
          automatic logic [7:0]  ea = q_addr.pop_front();
          automatic logic [31:0] ed = q_data.pop_front();
          automatic string       et = q_tag.pop_front();
          chk({et, " access kind"}, {31'h0, reg_wr}, {31'h0, ew});
          chk({et, " address"}, {24'h0, reg_addr}, {24'h0, ea});
          if (ew) chk({et, " write data"}, reg_wdata, ed);
        end
      end
    end
  end

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      miscompares++;
      $display("FAIL watchdog expired");
      finish_up();
    end
  end

  task automatic run_case(int tfn, logic [31:0] tfv, int isn, logic [31:0] isv, logic [31:0] civ,
                          logic [31:0] ctl0, logic [31:0] serr0, logic [31:0] gis0, bit extra_go);
    automatic logic [31:0] ctl1 = ctl0 | 32'h1;
    automatic logic exp_err;
    automatic int n = 0;
    cfg_tf_n = tfn; cfg_tf_v = tfv; cfg_is_n = isn; cfg_is_v = isv; cfg_ci = civ;
    cfg_ctl = ctl0; cfg_serr = serr0; cfg_gis = gis0;
    load = 1'b1; @(negedge clk); load = 1'b0;
    expect_acc(1, A_XFER, 32'h0, "R2");
    for (int i = 0; i < tfn; i++) expect_acc(0, A_TASK, 0, "R3");
    expect_acc(0, A_TASK, 0, "R3");
    expect_acc(0, A_CTL, 0, "R3");
    expect_acc(1, A_CTL, ctl1, "R3");
    expect_acc(1, A_ISSUE, 32'h1, "R4");
    if (isn >= POLL) begin
      for (int i = 0; i < POLL; i++) expect_acc(0, A_PIS, 0, "R10");
      exp_err = 1'b1;
    end else begin
      for (int i = 0; i <= isn; i++) expect_acc(0, A_PIS, 0, "R5");
      if (isv[6]) begin
        expect_acc(0, A_SERR, 0, "R6");
        expect_acc(1, A_SERR, serr0 & ~32'h0401_0000, "R6");
      end
      expect_acc(1, A_PIS, isv, "R5");
      expect_acc(0, A_GIS, 0, "R8");
      expect_acc(1, A_GIS, gis0, "R8");
      expect_acc(0, A_CTL, 0, "R9");
      expect_acc(0, A_ISSUE, 0, "R9");
      if (!civ[0]) expect_acc(1, A_CTL, ctl1 & ~32'h1, "R9");
      exp_err = ~|isv[2:0];
    end
    go = 1'b1; @(negedge clk); go = 1'b0;
    chk("R2 busy after go", {31'h0, busy}, 32'h1);
    if (extra_go) begin
      @(negedge clk); @(negedge clk);
      go = 1'b1; @(negedge clk); go = 1'b0;
    end
    while (!done && n < 400) begin @(negedge clk); n++; end
    chk("R11 done pulse seen", {31'h0, done}, 32'h1);
    chk(isn >= POLL ? "R10 timeout error" : "R7 outcome", {31'h0, error}, {31'h0, exp_err});
    chk("R2 R3 R5 R9 all accesses made", q_wr.size(), 32'h0);
    chk("R2 transfer count cleared", regs[6], 32'h0);
    @(negedge clk);
    chk("R11 busy low after done", {31'h0, busy}, 32'h0);
    chk("R11 done is one cycle", {31'h0, done}, 32'h0);
    repeat (3) @(negedge clk);
    chk("R11 error held while idle", {31'h0, error}, {31'h0, exp_err});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset outputs", {27'h0, busy, done, error, reg_rd, reg_wr}, 32'h0);
    // basic DMA-done path, stop write
    run_case(0, 0, 0, 32'h0000_0001, 32'h0, 32'h0000_0016, 32'h0, 32'h0000_0001, 0);
    // busy bit 7 polled, delayed status, slot still issued -> no stop write
    run_case(3, 32'h0000_0080, 2, 32'h0000_0004, 32'h1, 32'h0000_0010, 32'h0, 32'h0000_0003, 0);
    // data-request bit 3 polled, connect change with good status
    run_case(2, 32'h0000_0008, 1, 32'h0000_0041, 32'h0, 32'h0000_0006, 32'h0401_0003, 32'h0000_0001, 0);
    // status without any good bit -> error, still acknowledged
    run_case(0, 0, 0, 32'h4000_0000, 32'h0, 32'h0, 32'h0, 32'h0000_0001, 0);
    // connect change with bad status, all error bits set
    run_case(1, 32'h0000_0088, 0, 32'h0000_0048, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'h8000_0001, 0);
    // last poll before timeout still succeeds (PIO setup)
    run_case(0, 0, POLL - 1, 32'h0000_0002, 32'h0, 32'h0, 32'h0, 32'h0000_0001, 0);
    // timeout
    run_case(0, 0, POLL + 4, 32'h0000_0001, 32'h1, 32'h0, 32'h0, 32'h0, 0);
    // go during busy ignored; error from timeout cleared by new go
    run_case(1, 32'h0000_0080, 1, 32'h0000_0002, 32'h0, 32'h0000_0014, 32'h0, 32'h0000_0002, 1);
    repeat (4) @(negedge clk);
    finish_up();
  end
endmodule